// File: doc/BRIEF.md
# Receive Byte Queue with Per-Byte Status and Frame Length

This block is a byte queue that sits between a serial receiver and a host. Each byte is written together with four status bits: parity error, framing error, end-of-frame and idle. Those bits are stored in the same entry as the byte. When the host pops a byte, it sees the status that belongs to that byte and no other.

A frame length counter counts the bytes accepted into the queue during the current frame. When the end-of-frame byte is accepted, the count is captured into a held register, and the host can read that value until the next frame closes. Two single-cycle interrupt pulses are produced. One reports a byte lost because the queue was full. The other reports a completed frame.

The head entry is always visible at the read port (first-word fall-through). A pop strobe advances the queue to the next entry.

Top module: `rxq_tagged_fifo`

## Requirements
- R1: After reset, `empty` is 1, `full` is 0, `level` is 0, both interrupt pulses are 0 and `frame_len` is 0.
- R2: Bytes leave in the order they were accepted. While `empty` is 0, `out_byte` shows the oldest stored byte.
- R3: `out_tag` carries the status written with the byte shown on `out_byte`. The bit order is: bit 0 parity error, bit 1 framing error, bit 2 end-of-frame, bit 3 idle.
- R4: `level` equals the number of stored entries (0 to 32). `full` is 1 exactly when `level` is 32, and `empty` is 1 exactly when `level` is 0.
- R5: When `in_valid` is high while the queue is full and `pop` is low, the byte is dropped and the stored contents and `level` stay unchanged. `irq_overrun` is then high for exactly the one cycle after that clock edge.
- R6: A push and a pop in the same cycle while the queue is full are both performed. `level` stays 32 and the new byte becomes the youngest entry.
- R7: A `pop` while the queue is empty has no effect.
- R8: `irq_eof` is high for exactly the one cycle after the edge that accepts a byte with `in_eof` set. A dropped end-of-frame byte raises no `irq_eof`.
- R9: `frame_len` takes, at the same edge, the number of accepted bytes in the frame, counting the end-of-frame byte. It holds that value until the next accepted end-of-frame byte. Dropped bytes are not counted.
- R10: The running frame count saturates at 0xFFFF.
- R11: The first accepted byte after an end-of-frame byte starts a new count at 1, so a one-byte frame gives a length of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Write strobe for the incoming byte |
| in_byte | input | 8 | Incoming data byte |
| in_perr | input | 1 | Parity error flag for this byte |
| in_ferr | input | 1 | Framing error flag for this byte |
| in_idle | input | 1 | Idle-line flag for this byte |
| in_eof | input | 1 | This byte closes the frame |
| pop | input | 1 | Host removes the head entry |
| out_byte | output | 8 | Head entry data |
| out_tag | output | 4 | Head entry status {idle, eof, ferr, perr} |
| level | output | 6 | Number of stored entries |
| full | output | 1 | Queue holds 32 entries |
| empty | output | 1 | Queue holds no entries |
| irq_overrun | output | 1 | One-cycle pulse: byte dropped while full |
| irq_eof | output | 1 | One-cycle pulse: frame completed |
| frame_len | output | 16 | Length of the most recently completed frame |

## Verification
A wrong pointer or a wrong level in the queue shows at the ports in the first cycle after the faulty edge. `level`, `full` or `empty` stop matching the count of accepted writes minus pops, or `out_byte` and `out_tag` show an entry out of order. A tag bit shifted by one position shows on `out_tag` when that byte reaches the head. A running frame count that is off shows at the next end-of-frame byte, when `frame_len` is compared with the bench's own count. Errors in saturation and in restarting the count are aimed at directly, with a frame longer than 65535 bytes and a frame of a single byte.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
   localparam int TAG_W = 4;

   // Status carried with every byte; perr is bit 0, idle is bit 3.
   typedef struct packed {
      logic idle;
      logic eof;
      logic ferr;
      logic perr;
   } rxq_tag_t;

   function automatic rxq_tag_t make_tag(input logic perr, input logic ferr,
                                         input logic eof, input logic idle);
      rxq_tag_t t;
      t.perr = perr;
      t.ferr = ferr;
      t.eof  = eof;
      t.idle = idle;
      return t;
   endfunction
endpackage

// File: rtl/rxq_ring.sv
module rxq_ring #(
   parameter int DEPTH = 32,
   parameter int WORD_W = 12,
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int LW = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_req,
   input  logic [WORD_W-1:0] push_word,
   input  logic              pop_req,
   output logic [WORD_W-1:0] head_word,
   output logic [LW-1:0]     level,
   output logic              full,
   output logic              empty,
   output logic              push_done,
   output logic              push_drop
);
   localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);
   localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);
   localparam bit POW2 = (DEPTH & (DEPTH - 1)) == 0;

   if (DEPTH < 2) begin : g_bad_depth
      $error("rxq_ring: DEPTH must be at least 2");
   end
   if (WORD_W < 1) begin : g_bad_width
      $error("rxq_ring: WORD_W must be positive");
   end

   logic [WORD_W-1:0] mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr, wr_ptr_nx, rd_ptr_nx;
   logic do_pop;

   assign full  = (level == FULL_LVL);
   assign empty = (level == '0);

   assign do_pop    = pop_req && !empty;
   assign push_done = push_req && (!full || do_pop);
   assign push_drop = push_req && full && !do_pop;

   if (POW2) begin : g_wrap_free
      assign wr_ptr_nx = wr_ptr + AW'(1);
      assign rd_ptr_nx = rd_ptr + AW'(1);
   end else begin : g_wrap_cmp
      assign wr_ptr_nx = (wr_ptr == LAST_PTR) ? '0 : wr_ptr + AW'(1);
      assign rd_ptr_nx = (rd_ptr == LAST_PTR) ? '0 : rd_ptr + AW'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (push_done) wr_ptr <= wr_ptr_nx;
         if (do_pop)    rd_ptr <= rd_ptr_nx;
         case ({push_done, do_pop})
            2'b10:   level <= level + LW'(1);
            2'b01:   level <= level - LW'(1);
            default: level <= level;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (push_done) mem[wr_ptr] <= push_word;
   end

   assign head_word = mem[rd_ptr];

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      level <= FULL_LVL); // R4
   AST_DROP_KEEPS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      (push_req && full && !pop_req) |=> (level == FULL_LVL)); // R5
   AST_FULL_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
      (push_req && full && pop_req) |=> (level == FULL_LVL)); // R6
   AST_EMPTY_POP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && pop_req && !push_req) |=> empty); // R7
endmodule

// File: rtl/rxq_frame_len.sv
module rxq_frame_len #(
   parameter int LEN_W = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc,
   input  logic             acc_eof,
   output logic [LEN_W-1:0] frame_len,
   output logic             eof_pulse
);
   localparam logic [LEN_W-1:0] MAX_LEN = '1;

   if (LEN_W < 2) begin : g_bad_len
      $error("rxq_frame_len: LEN_W must be at least 2");
   end

   logic [LEN_W-1:0] run_cnt, base_cnt, next_cnt;
   logic             restart;

   assign base_cnt = restart ? '0 : run_cnt;

   if (SATURATE) begin : g_sat
      assign next_cnt = (base_cnt == MAX_LEN) ? MAX_LEN : base_cnt + LEN_W'(1);
   end else begin : g_wrap
      assign next_cnt = base_cnt + LEN_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_cnt   <= '0;
         restart   <= 1'b1;
         frame_len <= '0;
         eof_pulse <= 1'b0;
      end else begin
         eof_pulse <= acc && acc_eof;
         if (acc) begin
            run_cnt <= next_cnt;
            restart <= acc_eof;
            if (acc_eof) frame_len <= next_cnt;
         end
      end
   end

   AST_LEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !eof_pulse |-> $stable(frame_len)); // R9
   AST_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      eof_pulse |-> (frame_len != '0)); // R11
   AST_EOF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      eof_pulse |=> !eof_pulse || $past(acc && acc_eof)); // R8
endmodule

// File: rtl/rxq_tagged_fifo.sv
module rxq_tagged_fifo #(
   parameter int DEPTH = 32,
   parameter int DATA_W = 8,
   parameter int LEN_W = 16,
   parameter bit SATURATE = 1'b1,
   localparam int LW = $clog2(DEPTH + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   input  logic [DATA_W-1:0]      in_byte,
   input  logic                   in_perr,
   input  logic                   in_ferr,
   input  logic                   in_idle,
   input  logic                   in_eof,
   input  logic                   pop,
   output logic [DATA_W-1:0]      out_byte,
   output logic [rxq_pkg::TAG_W-1:0] out_tag,
   output logic [LW-1:0]          level,
   output logic                   full,
   output logic                   empty,
   output logic                   irq_overrun,
   output logic                   irq_eof,
   output logic [LEN_W-1:0]       frame_len
);
   import rxq_pkg::*;

   localparam int WORD_W = DATA_W + TAG_W;

   if (DATA_W < 1) begin : g_bad_data
      $error("rxq_tagged_fifo: DATA_W must be positive");
   end

   rxq_tag_t          wr_tag, rd_tag;
   logic [WORD_W-1:0] wr_word, rd_word;
   logic              push_done, push_drop;

   assign wr_tag  = make_tag(in_perr, in_ferr, in_eof, in_idle);
   assign wr_word = {wr_tag, in_byte};

   rxq_ring #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_ring (
      .clk       (clk),
      .rst_n     (rst_n),
      .push_req  (in_valid),
      .push_word (wr_word),
      .pop_req   (pop),
      .head_word (rd_word),
      .level     (level),
      .full      (full),
      .empty     (empty),
      .push_done (push_done),
      .push_drop (push_drop)
   );

   assign rd_tag   = rxq_tag_t'(rd_word[WORD_W-1:DATA_W]);
   assign out_byte = rd_word[DATA_W-1:0];
   assign out_tag  = rd_tag;

   rxq_frame_len #(.LEN_W(LEN_W), .SATURATE(SATURATE)) u_len (
      .clk       (clk),
      .rst_n     (rst_n),
      .acc       (push_done),
      .acc_eof   (in_eof),
      .frame_len (frame_len),
      .eof_pulse (irq_eof)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_overrun <= 1'b0;
      else        irq_overrun <= push_drop;
   end

   AST_OVERRUN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_overrun |-> $past(in_valid && full && !pop)); // R5
   AST_OVERRUN_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && full && !pop) |=> irq_overrun); // R5
   AST_EOF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_eof |-> $past(in_valid && in_eof && !(full && !pop))); // R8
   AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(full && empty)); // R4
endmodule

// File: tb/rxq_tagged_fifo_test.sv
module rxq_tagged_fifo_test;
   localparam int DEPTH = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0, in_perr = 1'b0, in_ferr = 1'b0, in_idle = 1'b0, in_eof = 1'b0, pop = 1'b0;
   logic [7:0] in_byte = '0;
   logic [7:0] out_byte;
   logic [3:0] out_tag;
   logic [5:0] level;
   logic full, empty, irq_overrun, irq_eof;
   logic [15:0] frame_len;

   int checks = 0;
   int fails = 0;

   always #5 clk = ~clk;

   rxq_tagged_fifo uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
      .in_perr(in_perr), .in_ferr(in_ferr), .in_idle(in_idle), .in_eof(in_eof),
      .pop(pop), .out_byte(out_byte), .out_tag(out_tag), .level(level),
      .full(full), .empty(empty), .irq_overrun(irq_overrun), .irq_eof(irq_eof),
      .frame_len(frame_len)
   );

   // Reference model: entries as {tag[3:0], byte[7:0]}.
   logic [11:0] mq[$];
   int unsigned m_cnt = 0;
   bit m_restart = 1'b1;
   logic [15:0] m_flen = '0;
   bit m_ovr = 1'b0, m_eofp = 1'b0;

   task automatic chk(input string req, input int unsigned act, input int unsigned exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int unsigned next_len(input int unsigned cnt, input bit restart);
      int unsigned b = restart ? 0 : cnt;
      return (b >= 16'hFFFF) ? 16'hFFFF : b + 1;
   endfunction

   task automatic model_update(input bit v, input logic [7:0] d, input logic [3:0] t, input bit p);
      bit was_full = (mq.size() == DEPTH);
      bit pop_ok = p && (mq.size() > 0);
      bit push_ok = v && (!was_full || pop_ok);
      m_ovr = v && was_full && !pop_ok;
      m_eofp = push_ok && t[2];
      if (pop_ok) void'(mq.pop_front());
      if (push_ok) begin
         mq.push_back({t, d});
         m_cnt = next_len(m_cnt, m_restart);
         m_restart = t[2];
         if (t[2]) m_flen = 16'(m_cnt);
      end
   endtask

   task automatic compare();
      chk("R4 level", level, mq.size());
      chk("R4 full", full, mq.size() == DEPTH);
      chk("R4 empty", empty, mq.size() == 0);
      chk("R5 irq_overrun", irq_overrun, m_ovr);
      chk("R8 irq_eof", irq_eof, m_eofp);
      chk("R9 frame_len", frame_len, m_flen);
      if (mq.size() > 0) begin
         chk("R2 out_byte", out_byte, mq[0][7:0]);
         chk("R3 out_tag", out_tag, mq[0][11:8]);
      end
   endtask

   // tag bits: 0 perr, 1 ferr, 2 eof, 3 idle
   task automatic step(input bit v, input logic [7:0] d, input logic [3:0] t, input bit p);
      in_valid = v; in_byte = d;
      in_perr = t[0]; in_ferr = t[1]; in_eof = t[2]; in_idle = t[3];
      pop = p;
      @(posedge clk);
      model_update(v, d, t, p);
      @(negedge clk);
      compare();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 empty", empty, 1);
      chk("R1 full", full, 0);
      chk("R1 level", level, 0);
      chk("R1 irqs", {irq_overrun, irq_eof}, 0);
      chk("R1 frame_len", frame_len, 0);

      // R7: pop while empty
      step(1'b0, 8'h00, 4'h0, 1'b1);
      chk("R7 still empty", empty, 1);

      // Fill to full with distinct tags (R2, R3, R4)
      for (int i = 0; i < DEPTH; i++) step(1'b1, 8'(i * 7 + 3), 4'(i & 4'hB), 1'b0);
      chk("R4 full at depth", full, 1);
      // R5: overrun drops byte, keeps head
      step(1'b1, 8'hEE, 4'h4, 1'b0);
      chk("R5 overrun pulse", irq_overrun, 1);
      chk("R5 head unchanged", out_byte, 8'h03);
      chk("R8 dropped eof no irq", irq_eof, 0);
      step(1'b0, 8'h00, 4'h0, 1'b0);
      chk("R5 pulse one cycle", irq_overrun, 0);
      // R6: push and pop while full
      step(1'b1, 8'h5A, 4'h9, 1'b1);
      chk("R6 level stays full", level, DEPTH);
      chk("R6 new head", out_byte, 8'h0A);
      // drain
      while (mq.size() > 0) step(1'b0, 8'h00, 4'h0, 1'b1);
      chk("R6 youngest was swapped byte", m_cnt, 33);

      // R11: one-byte frames
      step(1'b1, 8'h11, 4'h4, 1'b0);
      chk("R11 first frame len", frame_len, m_flen);
      step(1'b1, 8'h22, 4'h4, 1'b1);
      chk("R11 single byte frame", frame_len, 1);
      chk("R8 eof pulse", irq_eof, 1);
      step(1'b0, 8'h00, 4'h0, 1'b1);
      chk("R8 pulse one cycle", irq_eof, 0);

      // Random traffic
      for (int n = 0; n < 4000; n++) begin
         logic [3:0] t = 4'($urandom);
         t[2] = ($urandom_range(0, 9) == 0);
         step($urandom_range(0, 9) < 6, 8'($urandom), t, $urandom_range(0, 9) < 5);
      end
      while (mq.size() > 0) step(1'b0, 8'h00, 4'h0, 1'b1);
      step(1'b1, 8'h01, 4'h4, 1'b1);

      // R10: frame longer than 65535 bytes
      for (int n = 0; n < 65540; n++) step(1'b1, 8'(n), 4'h0, 1'b1);
      step(1'b1, 8'hFF, 4'h4, 1'b1);
      chk("R10 saturated length", frame_len, 16'hFFFF);
      step(1'b1, 8'h33, 4'h4, 1'b1);
      chk("R11 restart after saturated", frame_len, 1);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule